// File: doc/BRIEF.md
# I2S Master Transmit Serializer

This block is a transmit-only serial audio master. It makes the bit clock, the word-select line and the serial data line from its own master clock input. It takes 32-bit sample words from a show-ahead FIFO, one word per channel, and sends the left channel first. Each word goes out MSB first in the standard I2S format, in which word select changes one bit clock ahead of the MSB. Only the low `res` bits of each word are sent.

Control comes from three configuration inputs: `tx_en`, the 8-bit clock ratio `ratio` and the 6-bit resolution `res`. A half bit-clock period is `ratio + 2` master clocks. With the master clock at 256 times the sample rate, a ratio of 0 gives 32-bit stereo frames and a ratio of 2 gives 16-bit stereo frames.

When transmit is enabled, one stereo frame of zeros goes out before any FIFO data. If the FIFO is empty when a word starts (underrun), a zero word is sent and the framing keeps going. A new ratio or resolution is taken only at the start of a frame, that is, at the start of a left word.

The controller has three states:
- `ST_IDLE`: lines held low.
- `ST_PRIME`: the zero frame.
- `ST_STREAM`: FIFO data.

It has four transitions:
- START: `ST_IDLE` to `ST_PRIME` when `tx_en` is seen high.
- PRIMED: `ST_PRIME` to `ST_STREAM` at the end of the zero frame's right word.
- HOLD: a state stays where it is.
- HALT: any state to `ST_IDLE` in every cycle in which `tx_en` is low.

Top module: `aud_serial_tx`

## Requirements
- R1: While transmitting, `sclk_o` has a period of 2*(ratio+2) master clocks, high and low for ratio+2 cycles each, using the ratio in force for the current frame.
- R2: In any cycle in which `tx_en` is low, `fifo_pop` is low. From the next cycle on, `sclk_o`, `ws_o` and `sd_o` are all low.
- R3: After enable, the first frame is two all-zero words (left, then right). The FIFO is not popped during this frame, even if it holds data.
- R4: Each word carries the low N bits of the 32-bit FIFO word, MSB first. N is `res`, except that a `res` of 0 or above 32 is treated as 32.
- R5: `ws_o` is 0 for the left channel and 1 for the right. It takes the next channel's value during the last bit of the current word, one bit clock before the next MSB. `sd_o` and `ws_o` change only together with a falling edge of `sclk_o`.
- R6: In `ST_STREAM`, each new word pops the FIFO once, for one cycle. The pop occurs in the cycle that ends with `sclk_o` falling, so words go out in FIFO order, alternating left and right.
- R7: If the FIFO is empty at a word start, the word is sent as zeros without a pop, and the left/right alternation continues.
- R8: A change of `ratio` or `res` during a frame leaves that frame's two words unaffected. It applies from the next left word.
- R9: During reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| ratio | input | 8 | Bit clock ratio; half period is ratio+2 clocks |
| res | input | 6 | Bits sent per word (0 or >32 means 32) |
| fifo_data | input | 32 | Head word of the show-ahead FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | Consume the head word at this clock edge |
| sclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select, 0 = left |
| sd_o | output | 1 | Serial data |

## Verification
The bench uses the default parameters: 32-bit words, an 8-bit ratio and a 6-bit resolution. It keeps ratios between 0 and 3, so a bit slot lasts 4 to 10 master clocks and many frames fit into a short run. Resolutions of 0, 1 to 31, 16 and 32 cover the masking, the fallback to full width and the one-bit word-select lead at every word length. A receiver model samples the lines on each rising bit clock and rebuilds the words, so the zero frame, the underrun zeros and a mid-frame configuration change are all seen at the pins.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRIME  = 2'd1,
        ST_STREAM = 2'd2
    } tx_state_e;
endpackage

// File: rtl/aud_tx_bitclk.sv
module aud_tx_bitclk #(
    parameter int HALF_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half_len,
    output logic              sclk,
    output logic              fall_evt
);
    logic [HALF_W-1:0] hcnt_q;
    logic              wrap;

    assign wrap     = (hcnt_q == half_len - 1'b1);
    assign fall_evt = run && sclk && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt_q <= '0;
            sclk   <= 1'b0;
        end else if (!run) begin
            hcnt_q <= '0;
            sclk   <= 1'b0;
        end else if (wrap) begin
            hcnt_q <= '0;
            sclk   <= ~sclk;
        end else begin
            hcnt_q <= hcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/aud_tx_framer.sv
module aud_tx_framer
    import aud_tx_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int RATIO_W = 8,
    parameter int RES_W   = 6,
    parameter int HALF_W  = RATIO_W + 1,
    parameter int LEN_W   = $clog2(WORD_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic [RES_W-1:0]   res_in,
    input  logic [WORD_W-1:0]  fifo_data,
    input  logic               fifo_empty,
    input  logic               fall_evt,
    output logic               fifo_pop,
    output logic               run,
    output logic [HALF_W-1:0]  half_len,
    output logic               sd,
    output logic               ws
);
    tx_state_e          state_q, state_n;
    logic               chan_q, chan_n;
    logic [LEN_W-1:0]   bitcnt_q, bitcnt_n;
    logic [LEN_W-1:0]   nbits_q, nbits_n;
    logic [HALF_W-1:0]  half_q, half_n;
    logic [WORD_W-1:0]  sh_q, sh_n;
    logic               word_end;

    function automatic logic [LEN_W-1:0] eff_len(input logic [RES_W-1:0] r);
        if (r == '0 || int'(r) > WORD_W) return LEN_W'(WORD_W);
        return LEN_W'(r);
    endfunction

    assign word_end = (bitcnt_q == nbits_q - 1'b1);
    assign run      = tx_en && (state_q != ST_IDLE);
    assign half_len = half_q;

    always_comb begin
        state_n  = state_q;
        chan_n   = chan_q;
        bitcnt_n = bitcnt_q;
        nbits_n  = nbits_q;
        half_n   = half_q;
        sh_n     = sh_q;
        fifo_pop = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_en) begin
                    state_n  = ST_PRIME;
                    chan_n   = 1'b0;
                    bitcnt_n = '0;
                    nbits_n  = eff_len(res_in);
                    half_n   = HALF_W'(ratio_in) + HALF_W'(2);
                    sh_n     = '0;
                end
            end
            ST_PRIME, ST_STREAM: begin
                if (fall_evt) begin
                    if (word_end) begin
                        chan_n   = ~chan_q;
                        bitcnt_n = '0;
                        sh_n     = '0;
                        if (chan_q) begin
                            nbits_n = eff_len(res_in);
                            half_n  = HALF_W'(ratio_in) + HALF_W'(2);
                            if (state_q == ST_PRIME) state_n = ST_STREAM;
                        end
                        if (state_n == ST_STREAM && !fifo_empty) begin
                            fifo_pop = 1'b1;
                            sh_n     = fifo_data << (WORD_W - int'(nbits_n));
                        end
                    end else begin
                        sh_n     = sh_q << 1;
                        bitcnt_n = bitcnt_q + 1'b1;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (!tx_en) begin
            state_n  = ST_IDLE;
            fifo_pop = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            chan_q   <= 1'b0;
            bitcnt_q <= '0;
            nbits_q  <= LEN_W'(WORD_W);
            half_q   <= HALF_W'(2);
            sh_q     <= '0;
        end else begin
            state_q  <= state_n;
            chan_q   <= chan_n;
            bitcnt_q <= bitcnt_n;
            nbits_q  <= nbits_n;
            half_q   <= half_n;
            sh_q     <= sh_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sd <= 1'b0;
            ws <= 1'b0;
        end else if (state_n == ST_IDLE) begin
            sd <= 1'b0;
            ws <= 1'b0;
        end else begin
            sd <= sh_n[WORD_W-1];
            ws <= chan_n ^ (bitcnt_n == nbits_n - 1'b1);
        end
    end
endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx #(
    parameter int WORD_W  = 32,
    parameter int RATIO_W = 8,
    parameter int RES_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [RES_W-1:0]   res,
    input  logic [WORD_W-1:0]  fifo_data,
    input  logic               fifo_empty,
    output logic               fifo_pop,
    output logic               sclk_o,
    output logic               ws_o,
    output logic               sd_o
);
    localparam int HALF_W = RATIO_W + 1;
    localparam int LEN_W  = $clog2(WORD_W + 1);

    logic              run;
    logic              fall_evt;
    logic [HALF_W-1:0] half_len;

    aud_tx_framer #(
        .WORD_W (WORD_W),
        .RATIO_W(RATIO_W),
        .RES_W  (RES_W),
        .HALF_W (HALF_W),
        .LEN_W  (LEN_W)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .ratio_in  (ratio),
        .res_in    (res),
        .fifo_data (fifo_data),
        .fifo_empty(fifo_empty),
        .fall_evt  (fall_evt),
        .fifo_pop  (fifo_pop),
        .run       (run),
        .half_len  (half_len),
        .sd        (sd_o),
        .ws        (ws_o)
    );

    aud_tx_bitclk #(
        .HALF_W(HALF_W)
    ) u_bitclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .half_len(half_len),
        .sclk    (sclk_o),
        .fall_evt(fall_evt)
    );
endmodule

// File: rtl/aud_serial_tx_chk.sv
module aud_serial_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic fifo_empty,
    input logic fifo_pop,
    input logic sclk_o,
    input logic ws_o,
    input logic sd_o
);
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (!sclk_o && !ws_o && !sd_o)); // R2
    AST_NO_POP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !fifo_pop); // R2
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty); // R7
    AST_LINES_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> ($stable(sd_o) && $stable(ws_o))); // R5
    AST_POP_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> $fell(sclk_o)); // R6
    AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop); // R6
    AST_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk_o) && tx_en) |=> sclk_o); // R1
    AST_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sclk_o) && tx_en) |=> !sclk_o); // R1
endmodule

bind aud_serial_tx aud_serial_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .fifo_empty(fifo_empty),
    .fifo_pop  (fifo_pop),
    .sclk_o    (sclk_o),
    .ws_o      (ws_o),
    .sd_o      (sd_o)
);

// File: tb/aud_serial_tx_bench.sv
`timescale 1ns/1ps
module aud_serial_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic [7:0]  ratio = 8'd0;
    logic [5:0]  res = 6'd32;
    logic [31:0] fifo_data;
    logic        fifo_empty;
    logic        fifo_pop, sclk_o, ws_o, sd_o;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    aud_serial_tx u_aud_serial_tx (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ratio(ratio), .res(res),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
        .sclk_o(sclk_o), .ws_o(ws_o), .sd_o(sd_o)
    );

    // bench FIFO: mem/wr_ptr written by the stimulus, rd_ptr by the pop process
    logic [31:0] mem [0:255];
    logic [7:0]  wr_ptr = 8'd0;
    logic [7:0]  rd_ptr = 8'd0;
    logic        pend = 1'b0;
    int          pops = 0;
    assign fifo_data  = mem[rd_ptr];
    assign fifo_empty = (rd_ptr == wr_ptr);

    always @(negedge clk) begin
        logic now_pop;
        now_pop = fifo_pop;
        if (pend) begin
            rd_ptr = rd_ptr + 8'd1;
            pops   = pops + 1;
        end
        pend = now_pop;
    end

    // receiver model, samples on each rising bit clock
    int          run_id = 0;
    int          seen_id = 0;
    int          exp_per = 0;
    int          cyc = 0, last_rise = -1, per_bad = 0, nw = 0, blen = 0;
    logic [31:0] acc = '0;
    logic        ws_prev = 1'b0, sclk_prev = 1'b0;
    logic [31:0] rx_word [0:63];
    int          rx_len  [0:63];
    logic        rx_ch   [0:63];

    always @(negedge clk) begin
        if (run_id != seen_id) begin
            seen_id = run_id; nw = 0; blen = 0; acc = '0;
            ws_prev = 1'b0; last_rise = -1; per_bad = 0;
        end
        cyc = cyc + 1;
        if (sclk_o && !sclk_prev) begin
            if (last_rise >= 0 && exp_per != 0 && (cyc - last_rise) != exp_per)
                per_bad = per_bad + 1;
            last_rise = cyc;
            acc  = {acc[30:0], sd_o};
            blen = blen + 1;
            if (ws_o != ws_prev) begin
                if (nw < 64) begin
                    rx_word[nw] = acc; rx_len[nw] = blen; rx_ch[nw] = ~ws_o;
                end
                nw = nw + 1; acc = '0; blen = 0;
            end
            ws_prev = ws_o;
        end
        sclk_prev = sclk_o;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL all: watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_err + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int eff(input int r);
        return (r == 0 || r > 32) ? 32 : r;
    endfunction

    function automatic logic [31:0] mask_w(input logic [31:0] w, input int n);
        return (n >= 32) ? w : (w & ((32'h1 << n) - 32'h1));
    endfunction

    task automatic run_case(input int r, input int s, input int nwords,
                            input int cr, input int cs);
        logic [31:0] pushed [0:15];
        int   start_pops, n0, n1, total;
        logic [31:0] ev;
        bit   chg;
        chg = (cr >= 0);
        n0 = eff(s);
        n1 = chg ? eff(cs) : n0;
        for (int i = 0; i < nwords; i++) begin
            pushed[i] = $urandom;
            mem[wr_ptr] = pushed[i];
            wr_ptr = wr_ptr + 8'd1;
        end
        ratio = 8'(r); res = 6'(s);
        exp_per = chg ? 0 : 2 * (r + 2);
        run_id++;
        repeat (3) @(negedge clk);
        start_pops = pops;
        tx_en = 1'b1;
        if (chg) begin
            repeat (10) @(negedge clk);
            ratio = 8'(cr); res = 6'(cs);
        end
        total = nwords + 4;
        while (nw < total) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk({sclk_o, ws_o, sd_o, fifo_pop} == 4'b0, "R2 lines low after disable",
            {sclk_o, ws_o, sd_o, fifo_pop}, 0);
        repeat (6) @(negedge clk);
        chk({sclk_o, ws_o, sd_o} == 3'b0, "R2 lines stay low", {sclk_o, ws_o, sd_o}, 0);
        for (int i = 0; i < total; i++) begin
            int el;
            el = (i < 2) ? n0 : n1;
            if (i < 2)                ev = 32'h0;            // R3 zero frame
            else if (i < 2 + nwords)  ev = mask_w(pushed[i-2], el); // R4 R6
            else                      ev = 32'h0;            // R7 underrun
            chk(rx_word[i] == ev, (i < 2) ? "R3 prime word" :
                (i < 2 + nwords) ? "R4 data word" : "R7 underrun word", rx_word[i], ev);
            chk(rx_len[i] == el, chg ? "R8 word length" : "R4 word length", rx_len[i], el);
            chk(rx_ch[i] == 1'(i % 2), "R5 channel order", rx_ch[i], i % 2);
        end
        chk((pops - start_pops) == nwords, "R6 pop count", pops - start_pops, nwords);
        if (!chg) chk(per_bad == 0, "R1 bit clock period", per_bad, 0);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h00C0FFEE);
        repeat (4) @(negedge clk);
        chk({sclk_o, ws_o, sd_o, fifo_pop} == 4'b0, "R9 reset outputs",
            {sclk_o, ws_o, sd_o, fifo_pop}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({sclk_o, ws_o, sd_o} == 3'b0, "R2 idle after reset", {sclk_o, ws_o, sd_o}, 0);

        run_case(0, 32, 6, -1, -1);   // 32-bit stereo framing
        run_case(2, 16, 6, -1, -1);   // 16-bit stereo framing
        run_case(1, 0, 4, -1, -1);    // R4 resolution 0 means 32
        run_case(0, 40, 2, -1, -1);   // R4 resolution above 32 means 32
        run_case(0, 1, 4, -1, -1);    // one-bit words
        run_case(3, 16, 0, -1, -1);   // R7 FIFO empty throughout
        run_case(0, 32, 4, 2, 16);    // R8 change during the zero frame
        run_case(2, 16, 4, 0, 24);    // R8 change again
        for (int k = 0; k < 5; k++) begin
            int rr, ss;
            rr = int'($urandom % 4);
            case ($urandom % 3)
                0: ss = 16;
                1: ss = 32;
                default: ss = 1 + int'($urandom % 31);
            endcase
            run_case(rr, ss, 2 + int'($urandom % 8), -1, -1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule